// File: doc/BRIEF.md
# Dual Interval Timer with Shared Interrupt

This peripheral holds one or two independent 32-bit interval timers behind a small word-addressed register window. Software writes a load value, then writes a control word that picks the count direction, whether the timer reloads itself on expiry, and whether its expiry may drive the interrupt. Setting the run bit copies the load value into the live counter. The counter then moves one step per clock toward its terminal value: zero when counting down, all-ones when counting up.

On expiry a sticky per-timer flag is raised. With auto-reload set, the counter picks up the load value again and keeps going. Without it, the timer halts on the terminal value and drops its run bit. All timers drive a single interrupt line, which is high while any timer has both its flag and its interrupt-enable set. Software acknowledges an expiry by writing a one to the flag bit.

A parameter sets the number of timers. With one timer the window covers only the first timer's slots.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset, every control, load and counter register reads zero and `irq_out` is low.
- R2: Timer n sits at byte offset n*16. Within a timer, word 0 (offset +0x0) is control, word 1 (+0x4) is load and word 2 (+0x8) is the counter. Address bits 1:0 are ignored. The counter word, word 3 (+0xC) and any address at or above TIMER_COUNT*16 cannot be written, and words 3 and above read zero.
- R3: Only control bits 10:0 are stored, and bits 31:11 read zero. Bits 0, 2, 3, 5, 9 and 10 are kept as written but change no behaviour. With run (bit 7) clear, setting auto-reload (bit 4) does not move the counter.
- R4: A control write with bit 7 (run) set loads the counter from the load register on that clock edge. The counter then takes one step on each later edge.
- R5: With bit 1 (down) set, a running counter decrements by one per clock. It expires on the edge where it already holds zero.
- R6: With bit 1 clear, a running counter increments by one per clock. It expires on the edge where it already holds all-ones.
- R7: An expiry sets the flag (bit 8) of that timer.
- R8: With bit 4 (auto-reload) set, an expiry reloads the counter from the load register, and the timer keeps running.
- R9: With bit 4 clear, an expiry clears bit 7 and the counter holds its terminal value.
- R10: Writing 1 to bit 8 clears the flag and writing 0 keeps it. An expiry on the same edge as a clearing write leaves the flag set.
- R11: `irq_out` is high exactly when some timer has both bit 8 (flag) and bit 6 (interrupt enable) set.
- R12: With TIMER_COUNT = 1, only byte offsets 0x00 to 0x0F decode. Offsets from 0x10 upward read zero and ignore writes.
- R13: A control write with bit 7 clear stops the counter, which then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one full 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Shared interrupt, OR of enabled flags |

## Verification
The assertions assume that every bus access is a whole aligned word and that `bus_we` is sampled once per intended write. They also assume that a load value is written before the run bit that consumes it, because the start check compares against the load register as it stood on the starting edge. The bench drives address, data and strobe at the falling edge and holds the strobe for exactly one rising edge, so every write lands on a known edge. It reads back only between edges through the combinational read path, so a read never overlaps a write. The one deliberate collision, a flag-clearing write on the same edge as an expiry, is placed by counting edges from the start write.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W  = 32;
  localparam int CTRL_W = 11;

  // Control bit positions
  localparam int CB_MODE = 0;
  localparam int CB_DOWN = 1;
  localparam int CB_GOUT = 2;
  localparam int CB_CAPT = 3;
  localparam int CB_AUTO = 4;
  localparam int CB_LDBT = 5;
  localparam int CB_IEN  = 6;
  localparam int CB_RUN  = 7;
  localparam int CB_FLAG = 8;
  localparam int CB_PWM  = 9;
  localparam int CB_ALL  = 10;

  localparam int SLOT_SHIFT = 4;  // 16 bytes per timer

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_LOAD  = 2'd1,
    W_COUNT = 2'd2,
    W_SPARE = 2'd3
  } word_e;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic down);
    return down ? (c - CNT_W'(1)) : (c + CNT_W'(1));
  endfunction

  function automatic logic at_terminal(input logic [CNT_W-1:0] c,
                                       input logic down);
    return down ? (c == '0) : (c == '1);
  endfunction
endpackage

// File: rtl/ivt_addr_decode.sv
module ivt_addr_decode
  import ivt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_TMR  = 2,
  localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output word_e             word_o
);
  logic [ADDR_W-1:0] blk;
  logic [1:0]        unused_byte_lane;

  assign blk              = addr >> SLOT_SHIFT;
  assign hit_o            = blk < ADDR_W'(N_TMR);
  assign idx_o            = blk[IDX_W-1:0];
  assign word_o           = word_e'(addr[3:2]);
  assign unused_byte_lane = addr[1:0];
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_load,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              expire_o,
  output logic              irq_req_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              running;
  logic              terminal;
  logic              expire;

  assign running  = ctrl_q[CB_RUN];
  assign terminal = at_terminal(cnt_q, ctrl_q[CB_DOWN]);
  assign expire   = running & terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q          <= wdata[CTRL_W-1:0];
        ctrl_q[CB_FLAG] <= (ctrl_q[CB_FLAG] & ~wdata[CB_FLAG]) | expire;
        if (wdata[CB_RUN]) cnt_q <= load_q;
      end else if (expire) begin
        ctrl_q[CB_FLAG] <= 1'b1;
        if (ctrl_q[CB_AUTO]) cnt_q <= load_q;
        else                 ctrl_q[CB_RUN] <= 1'b0;
      end else if (running) begin
        cnt_q <= step_count(cnt_q, ctrl_q[CB_DOWN]);
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign load_o    = load_q;
  assign count_o   = cnt_q;
  assign expire_o  = expire;
  assign irq_req_o = ctrl_q[CB_FLAG] & ctrl_q[CB_IEN];

  p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wdata[CB_RUN] |=> (cnt_q == $past(load_q)) && ctrl_q[CB_RUN]);

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running && ctrl_q[CB_DOWN] && !expire && !wr_ctrl |=>
      cnt_q == ($past(cnt_q) - CNT_W'(1)));

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && !ctrl_q[CB_DOWN] && !expire && !wr_ctrl |=>
      cnt_q == ($past(cnt_q) + CNT_W'(1)));

  p_expire_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl_q[CB_FLAG]);

  p_auto_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl_q[CB_AUTO] && !wr_ctrl |=>
      (cnt_q == $past(load_q)) && ctrl_q[CB_RUN]);

  p_halt_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !ctrl_q[CB_AUTO] && !wr_ctrl |=> !ctrl_q[CB_RUN] && $stable(cnt_q));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_FLAG] && !(wr_ctrl && wdata[CB_FLAG]) |=> ctrl_q[CB_FLAG]);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !wr_ctrl |=> $stable(cnt_q));
endmodule

// File: rtl/ivt_read_select.sv
module ivt_read_select
  import ivt_pkg::*;
#(
  parameter int N_TMR  = 2,
  localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  word_e             word,
  input  logic [CTRL_W-1:0] ctrl_a  [N_TMR],
  input  logic [CNT_W-1:0]  load_a  [N_TMR],
  input  logic [CNT_W-1:0]  count_a [N_TMR],
  output logic [CNT_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    for (int g = 0; g < N_TMR; g++) begin
      if (hit && (idx == IDX_W'(g))) begin
        unique case (word)
          W_CTRL:  rdata = CNT_W'(ctrl_a[g]);
          W_LOAD:  rdata = load_a[g];
          W_COUNT: rdata = count_a[g];
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
  import ivt_pkg::*;
#(
  parameter int TIMER_COUNT = 2,
  parameter int ADDR_W      = 8,
  localparam int IDX_W      = (TIMER_COUNT > 1) ? $clog2(TIMER_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_out
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  word_e            word;

  logic [CTRL_W-1:0]      ctrl_a  [TIMER_COUNT];
  logic [CNT_W-1:0]       load_a  [TIMER_COUNT];
  logic [CNT_W-1:0]       count_a [TIMER_COUNT];
  logic [TIMER_COUNT-1:0] expire_v;
  logic [TIMER_COUNT-1:0] irq_req;

  ivt_addr_decode #(.ADDR_W(ADDR_W), .N_TMR(TIMER_COUNT)) u_dec (
    .addr   (bus_addr),
    .hit_o  (hit),
    .idx_o  (idx),
    .word_o (word)
  );

  for (genvar g = 0; g < TIMER_COUNT; g++) begin : g_tmr
    logic sel;
    assign sel = bus_we && hit && (idx == IDX_W'(g));

    ivt_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (sel && (word == W_CTRL)),
      .wr_load   (sel && (word == W_LOAD)),
      .wdata     (bus_wdata),
      .ctrl_o    (ctrl_a[g]),
      .load_o    (load_a[g]),
      .count_o   (count_a[g]),
      .expire_o  (expire_v[g]),
      .irq_req_o (irq_req[g])
    );
  end

  ivt_read_select #(.N_TMR(TIMER_COUNT)) u_rd (
    .hit     (hit),
    .idx     (idx),
    .word    (word),
    .ctrl_a  (ctrl_a),
    .load_a  (load_a),
    .count_a (count_a),
    .rdata   (bus_rdata)
  );

  assign irq_out = |irq_req;

  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> bus_rdata == '0);

  p_ctrl_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (word == W_CTRL) |-> bus_rdata[CNT_W-1:CTRL_W] == '0);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(expire_v != '0) || $past(bus_we));
endmodule

// File: tb/sim_interval_timer_pair.sv
module sim_interval_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a0 = '0, a1 = '0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [31:0] wd0 = '0, wd1 = '0;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  interval_timer_pair u0 (.clk(clk), .rst_n(rst_n), .bus_addr(a0), .bus_we(we0),
    .bus_wdata(wd0), .bus_rdata(rd0), .irq_out(irq0));

  interval_timer_pair #(.TIMER_COUNT(1)) u1 (.clk(clk), .rst_n(rst_n),
    .bus_addr(a1), .bus_we(we1), .bus_wdata(wd1), .bus_rdata(rd1), .irq_out(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    a0 = ad; wd0 = d; we0 = 1'b1;
    @(posedge clk); @(negedge clk);
    we0 = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, output logic [31:0] d);
    a0 = ad; #1; d = rd0;
  endtask

  task automatic wr1(input logic [7:0] ad, input logic [31:0] d);
    a1 = ad; wd1 = d; we1 = 1'b1;
    @(posedge clk); @(negedge clk);
    we1 = 1'b0;
  endtask

  task automatic rd1_t(input logic [7:0] ad, output logic [31:0] d);
    a1 = ad; #1; d = rd1;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 12; i++) begin
      rd(8'(i * 4), v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq0}, 32'h0);
    chk("R1 irq after reset single", {31'b0, irq1}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, v); chk("R2 load readback", v, 32'h1234_5678);
    rd(8'h07, v); chk("R2 low addr bits ignored", v, 32'h1234_5678);
    rd(8'h14, v); chk("R2 timer1 load separate", v, 32'h0);
    wr(8'h08, 32'h0000_ABCD);
    rd(8'h08, v); chk("R2 counter write ignored", v, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R2 word3 reads zero", v, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R2 outside window zero", v, 32'h0);
    rd(8'h04, v); chk("R2 outside write left load", v, 32'h1234_5678);
    wr(8'h00, 32'hFFFF_F63D);
    rd(8'h00, v); chk("R3 ctrl stored low bits", v, 32'h0000_063D);
    waitc(5);
    rd(8'h08, v); chk("R3 inert bits no count", v, 32'h0);
    chk("R3 inert bits no irq", {31'b0, irq0}, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_down_oneshot;
    logic [31:0] v;
    wr(8'h04, 32'd10);
    wr(8'h00, 32'h82);
    rd(8'h08, v); chk("R4 counter loaded on start", v, 32'd10);
    waitc(3);
    rd(8'h08, v); chk("R5 down step", v, 32'd7);
    waitc(7);
    rd(8'h08, v); chk("R5 reached zero", v, 32'd0);
    rd(8'h00, v); chk("R7 flag not before expiry", v, 32'h82);
    waitc(1);
    rd(8'h00, v); chk("R7 R9 flag set run cleared", v, 32'h102);
    chk("R11 flag without enable no irq", {31'b0, irq0}, 32'h0);
    waitc(5);
    rd(8'h08, v); chk("R9 counter holds terminal", v, 32'd0);
  endtask

  task automatic t_flag_write;
    logic [31:0] v;
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R10 write 0 keeps flag", v, 32'h100);
    wr(8'h00, 32'h100);
    rd(8'h00, v); chk("R10 write 1 clears flag", v, 32'h0);
  endtask

  task automatic t_up_reload;
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFF0);
    wr(8'h10, 32'h90);
    waitc(15);
    rd(8'h18, v); chk("R6 up count at all-ones", v, 32'hFFFF_FFFF);
    waitc(1);
    rd(8'h18, v); chk("R8 reloaded after expiry", v, 32'hFFFF_FFF0);
    rd(8'h10, v); chk("R8 still running flag set", v, 32'h190);
    waitc(1);
    rd(8'h18, v); chk("R6 counting after reload", v, 32'hFFFF_FFF1);
    wr(8'h10, 32'h110);
    rd(8'h10, v); chk("R10 R13 stop and clear", v, 32'h010);
    rd(8'h18, v); chk("R13 stopped value", v, 32'hFFFF_FFF1);
    waitc(4);
    rd(8'h18, v); chk("R13 counter held", v, 32'hFFFF_FFF1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h04, 32'd2);
    wr(8'h00, 32'hC2);
    waitc(2);
    chk("R11 irq low before expiry", {31'b0, irq0}, 32'h0);
    waitc(1);
    chk("R11 irq high on flag+enable", {31'b0, irq0}, 32'h1);
    wr(8'h00, 32'h40);
    chk("R11 irq stays while flag kept", {31'b0, irq0}, 32'h1);
    wr(8'h00, 32'h140);
    chk("R11 irq drops on clear", {31'b0, irq0}, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h82);
    waitc(3);
    wr(8'h00, 32'h100);  // lands on the expiry edge
    rd(8'h00, v); chk("R10 expiry wins over clear", v, 32'h100);
    rd(8'h08, v); chk("R10 counter at terminal", v, 32'h0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    wr1(8'h04, 32'h55);
    rd1_t(8'h04, v); chk("R12 single load works", v, 32'h55);
    wr1(8'h14, 32'h77);
    rd1_t(8'h14, v); chk("R12 second slot absent", v, 32'h0);
    rd1_t(8'h10, v); chk("R12 second ctrl absent", v, 32'h0);
    rd1_t(8'h04, v); chk("R12 load unchanged", v, 32'h55);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    t_reset();
    t_map();
    t_down_oneshot();
    t_flag_write();
    t_up_reload();
    t_irq();
    t_collide();
    t_single();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule